// File: doc/BRIEF.md
# Interrupt Redirection and Destination Resolver

This block watches a vector of interrupt input pins and, for each pin, a redirection entry supplied by the surrounding logic. When an unmasked pin makes a fresh low-to-high transition, the block marks that pin pending. When its output stage is free, it services the lowest-numbered pending pin. From that pin's entry it builds an interrupt message and resolves the set of target processors. The result is presented as message fields plus a processor bitmap on a valid/ready output.

The target set is resolved in one of two ways. Physical destination mode either broadcasts or names a single processor ID. Logical destination mode matches the message destination against each processor's 8-bit logical destination value. The lowest-priority delivery mode is approximated by round-robin: a rotating offset picks one member of the matched set. The external-interrupt delivery mode takes its vector from a legacy controller input and pulses an acknowledge back to it. Two kinds of message are dropped and reported through single-cycle status pulses: a message whose target set is empty, and lowest-priority delivery requested in physical mode.

Top module: `irr_dest_resolver`

## Requirements

Entry layout in `redir_i`, per pin p at bits [p*23 +: 23]:

| Bits | Field |
|------|-------|
| 7:0 | vector |
| 10:8 | delivery mode: 000 fixed, 001 lowest priority, 111 external |
| 11 | destination mode: 1 logical, 0 physical |
| 12 | polarity |
| 13 | trigger mode |
| 14 | mask |
| 22:15 | destination |

The requirements:

- R1: Only a low-to-high transition of a pin, seen at a clock edge, produces a message. A pin held high produces no further message.
- R2: Lowering a pin only clears the block's record of the pin level. A later rise produces a new message.
- R3: A rise on a pin whose mask bit (bit 14) is set produces no message and no status pulse. This still holds if the pin is unmasked afterwards.
- R4: A message copies the entry's destination, delivery mode, destination mode and trigger mode. Its level bit equals the entry's polarity. For all delivery modes except external, its vector is the entry vector.
- R5: With delivery mode 111, the message vector is `ext_vec_i` sampled at the service edge. `ext_ack_o` is high for exactly the first cycle that message is valid.
- R6: In physical mode, destination 0xFF sets every bit of `msg_tgt_o`.
- R7: In physical mode, any other destination sets only bit d of `msg_tgt_o`, where d is the destination value.
- R8: Lowest-priority delivery in physical mode produces no message and a one-cycle `illegal_o` pulse.
- R9: In logical mode, bit i of the target bitmap is set when `ldr_i[i*8 +: 8]` ANDed with the destination is non-zero.
- R10: Logical lowest-priority delivery targets only one processor. That processor is the matched one at position (offset mod matched count), counting matched processors in ascending ID. The offset starts at 0 and increments once after each such delivery.
- R11: An empty target set produces no message and a one-cycle `empty_o` pulse, and leaves the offset unchanged.
- R12: Among pending pins, the lowest-numbered is serviced first. The others stay pending and are serviced one at a time.
- R13: While `msg_valid_o` is high and `msg_ready_i` is low, all message outputs hold. No new message is loaded until the current one is accepted.
- R14: After reset, `msg_valid_o`, `illegal_o`, `empty_o` and `ext_ack_o` are low.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| pin_i | input | NPINS | interrupt input pins |
| redir_i | input | NPINS*23 | per-pin redirection entries |
| ldr_i | input | NCPU*8 | per-processor logical destination values |
| ext_vec_i | input | 8 | vector from the legacy controller |
| ext_ack_o | output | 1 | legacy vector consumed |
| msg_ready_i | input | 1 | consumer accepts the message |
| msg_valid_o | output | 1 | message present |
| msg_vec_o | output | 8 | message vector |
| msg_dest_o | output | 8 | message destination |
| msg_dlv_o | output | 3 | delivery mode |
| msg_dmode_o | output | 1 | destination mode |
| msg_level_o | output | 1 | level bit (entry polarity) |
| msg_trig_o | output | 1 | trigger mode |
| msg_tgt_o | output | NCPU | target processor bitmap |
| illegal_o | output | 1 | physical lowest-priority request dropped |
| empty_o | output | 1 | empty target set dropped |

## Verification

The bench builds the block with eight pins and four processors. With four processors, a physical destination of 5 is out of range, so the empty-set drop can be reached without logical mode. Three logical values matching out of four give a set size that is not a power of two, so the round-robin wrap exercises a true modulo rather than a bit slice. Eight pins leave room to hold one pin high while others are serviced, and to raise two pins in the same cycle for the ordering check.

// File: rtl/irr_pkg.sv
package irr_pkg;

    localparam int VEC_W   = 8;
    localparam int DST_W   = 8;
    localparam int ENTRY_W = 23;

    typedef enum logic [2:0] {
        DLV_FIXED  = 3'b000,
        DLV_LOWPRI = 3'b001,
        DLV_SMI    = 3'b010,
        DLV_NMI    = 3'b100,
        DLV_INIT   = 3'b101,
        DLV_EXTINT = 3'b111
    } dlv_e;

    typedef struct packed {
        logic [DST_W-1:0] dest;
        logic             mask;
        logic             trig;
        logic             pol;
        logic             dmode;
        dlv_e             dlv;
        logic [VEC_W-1:0] vec;
    } entry_t;

    typedef struct packed {
        logic [DST_W-1:0] dest;
        dlv_e             dlv;
        logic             dmode;
        logic             level;
        logic             trig;
        logic [VEC_W-1:0] vec;
    } msg_t;

    function automatic logic is_lowpri(dlv_e d);
        return d == DLV_LOWPRI;
    endfunction

    function automatic logic is_ext(dlv_e d);
        return d == DLV_EXTINT;
    endfunction

endpackage

// File: rtl/irr_edge.sv
module irr_edge #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] mask_i,
    input  logic [NPINS-1:0] clr_i,
    output logic [NPINS-1:0] pend_o
);
    logic [NPINS-1:0] lvl_q;
    logic [NPINS-1:0] pend_q;
    logic [NPINS-1:0] rise;

    assign rise   = pin_i & ~lvl_q;
    assign pend_o = pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            pend_q <= '0;
        end else begin
            lvl_q  <= pin_i;
            pend_q <= (pend_q & ~clr_i) | (rise & ~mask_i);
        end
    end
endmodule

// File: rtl/irr_pick.sv
module irr_pick #(
    parameter int NPINS = 8,
    localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic [NPINS-1:0] pend_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (pend_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |pend_i;
endmodule

// File: rtl/irr_resolve.sv
module irr_resolve
    import irr_pkg::*;
#(
    parameter int NCPU  = 4,
    parameter int OFS_W = 8
) (
    input  logic [DST_W-1:0]  dest_i,
    input  dlv_e              dlv_i,
    input  logic              dmode_i,
    input  logic [NCPU*8-1:0] ldr_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [NCPU-1:0]   tgt_o,
    output logic              illegal_o,
    output logic              empty_o,
    output logic              rr_o
);
    localparam int CNT_W = $clog2(NCPU + 1);

    logic [NCPU-1:0]  phys_map;
    logic [NCPU-1:0]  logi_map;
    logic [NCPU-1:0]  base;
    logic [NCPU-1:0]  sel;
    logic [CNT_W-1:0] cnt;
    logic [OFS_W-1:0] pos;
    logic [OFS_W-1:0] seen;

    genvar g;
    generate
        for (g = 0; g < NCPU; g++) begin : g_cpu
            assign logi_map[g] = |(ldr_i[g*8 +: 8] & dest_i);
            assign phys_map[g] = (dest_i == 8'hFF) || (dest_i == DST_W'(g));
        end
    endgenerate

    assign base = dmode_i ? logi_map : phys_map;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < NCPU; i++) cnt = cnt + CNT_W'(base[i]);
    end

    assign pos = ofs_i % ((cnt == '0) ? OFS_W'(1) : OFS_W'(cnt));

    always_comb begin
        sel  = '0;
        seen = '0;
        for (int i = 0; i < NCPU; i++) begin
            if (base[i]) begin
                if (seen == pos) sel[i] = 1'b1;
                seen = seen + 1'b1;
            end
        end
    end

    assign illegal_o = !dmode_i && is_lowpri(dlv_i);
    assign rr_o      = dmode_i && is_lowpri(dlv_i) && (cnt != '0);
    assign tgt_o     = rr_o ? sel : base;
    assign empty_o   = !illegal_o && (tgt_o == '0);
endmodule

// File: rtl/irr_dest_resolver.sv
module irr_dest_resolver
    import irr_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int NCPU  = 4,
    parameter int OFS_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPINS-1:0]         pin_i,
    input  logic [NPINS*ENTRY_W-1:0] redir_i,
    input  logic [NCPU*8-1:0]        ldr_i,
    input  logic [7:0]               ext_vec_i,
    output logic                     ext_ack_o,
    input  logic                     msg_ready_i,
    output logic                     msg_valid_o,
    output logic [7:0]               msg_vec_o,
    output logic [7:0]               msg_dest_o,
    output logic [2:0]               msg_dlv_o,
    output logic                     msg_dmode_o,
    output logic                     msg_level_o,
    output logic                     msg_trig_o,
    output logic [NCPU-1:0]          msg_tgt_o,
    output logic                     illegal_o,
    output logic                     empty_o
);
    localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;

    entry_t           ent [NPINS];
    logic [NPINS-1:0] mask_v;
    logic [NPINS-1:0] pend;
    logic [NPINS-1:0] clr;
    logic             any;
    logic [IDX_W-1:0] idx;
    entry_t           cur;
    logic             take;

    logic [NCPU-1:0]  r_tgt;
    logic             r_illegal;
    logic             r_empty;
    logic             r_rr;

    msg_t             msg_q;
    logic [NCPU-1:0]  tgt_q;
    logic             valid_q;
    logic             illegal_q;
    logic             empty_q;
    logic             ack_q;
    logic [OFS_W-1:0] ofs_q;

    genvar g;
    generate
        for (g = 0; g < NPINS; g++) begin : g_ent
            assign ent[g]    = entry_t'(redir_i[g*ENTRY_W +: ENTRY_W]);
            assign mask_v[g] = ent[g].mask;
        end
    endgenerate

    irr_edge #(.NPINS(NPINS)) edge_i (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_i),
        .mask_i (mask_v),
        .clr_i  (clr),
        .pend_o (pend)
    );

    irr_pick #(.NPINS(NPINS)) pick_i (
        .pend_i (pend),
        .any_o  (any),
        .idx_o  (idx)
    );

    assign take = any && !valid_q;
    assign clr  = take ? (NPINS'(1) << idx) : '0;
    assign cur  = ent[idx];

    irr_resolve #(.NCPU(NCPU), .OFS_W(OFS_W)) res_i (
        .dest_i    (cur.dest),
        .dlv_i     (cur.dlv),
        .dmode_i   (cur.dmode),
        .ldr_i     (ldr_i),
        .ofs_i     (ofs_q),
        .tgt_o     (r_tgt),
        .illegal_o (r_illegal),
        .empty_o   (r_empty),
        .rr_o      (r_rr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            illegal_q <= 1'b0;
            empty_q   <= 1'b0;
            ack_q     <= 1'b0;
            ofs_q     <= '0;
            msg_q     <= '0;
            tgt_q     <= '0;
        end else begin
            illegal_q <= 1'b0;
            empty_q   <= 1'b0;
            ack_q     <= 1'b0;
            if (valid_q && msg_ready_i) valid_q <= 1'b0;
            if (take) begin
                if (r_illegal) begin
                    illegal_q <= 1'b1;
                end else if (r_empty) begin
                    empty_q <= 1'b1;
                end else begin
                    valid_q     <= 1'b1;
                    tgt_q       <= r_tgt;
                    msg_q.dest  <= cur.dest;
                    msg_q.dlv   <= cur.dlv;
                    msg_q.dmode <= cur.dmode;
                    msg_q.level <= cur.pol;
                    msg_q.trig  <= cur.trig;
                    msg_q.vec   <= is_ext(cur.dlv) ? ext_vec_i : cur.vec;
                    ack_q       <= is_ext(cur.dlv);
                    if (r_rr) ofs_q <= ofs_q + 1'b1;
                end
            end
        end
    end

    assign msg_valid_o = valid_q;
    assign msg_vec_o   = msg_q.vec;
    assign msg_dest_o  = msg_q.dest;
    assign msg_dlv_o   = msg_q.dlv;
    assign msg_dmode_o = msg_q.dmode;
    assign msg_level_o = msg_q.level;
    assign msg_trig_o  = msg_q.trig;
    assign msg_tgt_o   = tgt_q;
    assign illegal_o   = illegal_q;
    assign empty_o     = empty_q;
    assign ext_ack_o   = ack_q;
endmodule

// File: rtl/irr_chk.sv
module irr_chk #(
    parameter int NCPU = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            msg_ready_i,
    input logic            msg_valid_o,
    input logic [7:0]      msg_vec_o,
    input logic [7:0]      msg_dest_o,
    input logic [2:0]      msg_dlv_o,
    input logic            msg_dmode_o,
    input logic [NCPU-1:0] msg_tgt_o,
    input logic            illegal_o,
    input logic            empty_o,
    input logic            ext_ack_o
);
    // R13
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_tgt_o)
            && $stable(msg_vec_o) && $stable(msg_dest_o));

    // R11
    nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid_o |-> msg_tgt_o != '0);

    // R10
    lowpri_single_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid_o && msg_dmode_o && msg_dlv_o == 3'b001 |-> $countones(msg_tgt_o) == 1);

    // R7
    phys_single_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid_o && !msg_dmode_o && msg_dest_o != 8'hFF |-> $countones(msg_tgt_o) == 1);

    // R6
    bcast_all_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid_o && !msg_dmode_o && msg_dest_o == 8'hFF |-> msg_tgt_o == '1);

    // R8
    illegal_nomsg_chk: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> !$rose(msg_valid_o) && !empty_o);

    // R5
    ext_ack_chk: assert property (@(posedge clk) disable iff (rst)
        ext_ack_o |-> $rose(msg_valid_o) && msg_dlv_o == 3'b111);
endmodule

bind irr_dest_resolver irr_chk #(.NCPU(NCPU)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .msg_ready_i (msg_ready_i),
    .msg_valid_o (msg_valid_o),
    .msg_vec_o   (msg_vec_o),
    .msg_dest_o  (msg_dest_o),
    .msg_dlv_o   (msg_dlv_o),
    .msg_dmode_o (msg_dmode_o),
    .msg_tgt_o   (msg_tgt_o),
    .illegal_o   (illegal_o),
    .empty_o     (empty_o),
    .ext_ack_o   (ext_ack_o)
);

// File: tb/irr_dest_resolver_tb.sv
module irr_dest_resolver_tb_top;
    localparam int NPINS = 8;
    localparam int NCPU  = 4;
    localparam int EW    = 23;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NPINS-1:0]  pins = '0;
    logic [EW-1:0]     ent [NPINS];
    logic [NPINS*EW-1:0] redir;
    logic [NCPU*8-1:0] ldr;
    logic [7:0]        ext_vec = 8'h00;
    logic              ready = 1'b0;
    logic              ext_ack, valid, dmode, level, trig, illegal, empty;
    logic [7:0]        vec, dest;
    logic [2:0]        dlv;
    logic [NCPU-1:0]   tgt;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NPINS; i++) redir[i*EW +: EW] = ent[i];
    end

    irr_dest_resolver #(.NPINS(NPINS), .NCPU(NCPU), .OFS_W(8)) dut_i (
        .clk(clk), .rst(rst), .pin_i(pins), .redir_i(redir), .ldr_i(ldr),
        .ext_vec_i(ext_vec), .ext_ack_o(ext_ack), .msg_ready_i(ready),
        .msg_valid_o(valid), .msg_vec_o(vec), .msg_dest_o(dest),
        .msg_dlv_o(dlv), .msg_dmode_o(dmode), .msg_level_o(level),
        .msg_trig_o(trig), .msg_tgt_o(tgt), .illegal_o(illegal), .empty_o(empty)
    );

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_ent(int p, logic [7:0] v, logic [2:0] d, bit dm, bit pol,
                           bit trg, bit msk, logic [7:0] ds);
        ent[p] = {ds, msk, trg, pol, dm, d, v};
    endtask

    task automatic fire(int p);
        @(negedge clk) pins[p] = 1'b1;
        @(negedge clk) pins[p] = 1'b0;
    endtask

    // 1 = message, 2 = illegal pulse, 3 = empty pulse, 0 = nothing
    task automatic wait_evt(output int kind);
        kind = 0;
        for (int n = 0; n < 10; n++) begin
            @(negedge clk);
            if (valid) begin kind = 1; break; end
            if (illegal) begin kind = 2; break; end
            if (empty) begin kind = 3; break; end
        end
    endtask

    task automatic expect_msg(string req, logic [3:0] et, logic [7:0] ev,
                              logic [7:0] ed, logic [2:0] edl, bit edm,
                              bit elv, bit etr, bit eack);
        int k;
        wait_evt(k);
        chk({req, " message present"}, k, 1);
        if (k == 1) begin
            chk({req, " targets"}, tgt, et);
            chk({req, " vector"}, vec, ev);
            chk({req, " dest"}, dest, ed);
            chk({req, " delivery"}, dlv, edl);
            chk({req, " dmode"}, dmode, edm);
            chk({req, " level"}, level, elv);
            chk({req, " trig"}, trig, etr);
            chk({req, " ext ack"}, ext_ack, eack);
            ready = 1'b1;
            @(negedge clk) ready = 1'b0;
        end
    endtask

    task automatic expect_flag(string req, int kind);
        int k;
        wait_evt(k);
        chk({req, " status pulse"}, k, kind);
        @(negedge clk);
        chk({req, " pulse one cycle"}, {illegal, empty, valid}, 0);
    endtask

    task automatic expect_quiet(string req, int n);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (valid || illegal || empty) hits++;
        end
        chk({req, " no output"}, hits, 0);
    endtask

    task automatic t_reset();
        chk("R14 valid", valid, 0);
        chk("R14 illegal", illegal, 0);
        chk("R14 empty", empty, 0);
        chk("R14 ext ack", ext_ack, 0);
    endtask

    task automatic t_fields();
        set_ent(0, 8'h31, 3'b000, 0, 1, 1, 0, 8'h02);
        fire(0);
        expect_msg("R4 R7 physical fixed", 4'b0100, 8'h31, 8'h02, 3'b000, 0, 1, 1, 0);
    endtask

    task automatic t_bcast();
        set_ent(1, 8'h42, 3'b100, 0, 0, 0, 0, 8'hFF);
        fire(1);
        expect_msg("R6 broadcast", 4'b1111, 8'h42, 8'hFF, 3'b100, 0, 0, 0, 0);
    endtask

    task automatic t_phys_oob();
        set_ent(1, 8'h43, 3'b000, 0, 0, 0, 0, 8'h05);
        fire(1);
        expect_flag("R11 physical out of range", 3);
    endtask

    task automatic t_ext();
        ext_vec = 8'h5C;
        set_ent(3, 8'h11, 3'b111, 0, 0, 1, 0, 8'h01);
        fire(3);
        expect_msg("R5 external vector", 4'b0010, 8'h5C, 8'h01, 3'b111, 0, 0, 1, 1);
        chk("R5 ack single cycle", ext_ack, 0);
    endtask

    task automatic t_illegal();
        set_ent(4, 8'h20, 3'b001, 0, 0, 0, 0, 8'h00);
        fire(4);
        expect_flag("R8 physical lowest priority", 2);
    endtask

    task automatic t_mask();
        set_ent(5, 8'h55, 3'b000, 0, 0, 0, 1, 8'h00);
        fire(5);
        expect_quiet("R3 masked rise", 6);
        set_ent(5, 8'h55, 3'b000, 0, 0, 0, 0, 8'h00);
        expect_quiet("R3 unmasked later", 4);
    endtask

    task automatic t_edge();
        set_ent(6, 8'h66, 3'b000, 1, 1, 0, 0, 8'h0A);
        @(negedge clk) pins[6] = 1'b1;
        expect_msg("R1 R9 logical fixed", 4'b1010, 8'h66, 8'h0A, 3'b000, 1, 1, 0, 0);
        expect_quiet("R1 held high", 6);
        @(negedge clk) pins[6] = 1'b0;
        expect_quiet("R2 lowered", 2);
        fire(6);
        expect_msg("R2 rise again", 4'b1010, 8'h66, 8'h0A, 3'b000, 1, 1, 0, 0);
    endtask

    task automatic t_priority();
        set_ent(2, 8'h22, 3'b000, 0, 0, 0, 0, 8'h03);
        @(negedge clk) begin pins[2] = 1'b1; pins[5] = 1'b1; end
        @(negedge clk) begin pins[2] = 1'b0; pins[5] = 1'b0; end
        expect_msg("R12 lower pin first", 4'b1000, 8'h22, 8'h03, 3'b000, 0, 0, 0, 0);
        expect_msg("R12 higher pin next", 4'b0001, 8'h55, 8'h00, 3'b000, 0, 0, 0, 0);
    endtask

    task automatic t_handshake();
        int k;
        set_ent(0, 8'h31, 3'b000, 0, 1, 1, 0, 8'h02);
        set_ent(1, 8'h77, 3'b000, 0, 0, 0, 0, 8'h00);
        fire(0);
        wait_evt(k);
        chk("R13 first present", k, 1);
        fire(1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R13 held valid", valid, 1);
            chk("R13 held targets", tgt, 4'b0100);
            chk("R13 held vector", vec, 8'h31);
        end
        ready = 1'b1;
        @(negedge clk) ready = 1'b0;
        expect_msg("R13 second after accept", 4'b0001, 8'h77, 8'h00, 3'b000, 0, 0, 0, 0);
    endtask

    task automatic t_lowpri();
        set_ent(7, 8'h70, 3'b001, 1, 0, 0, 0, 8'h07);
        fire(7);
        expect_msg("R10 offset 0", 4'b0001, 8'h70, 8'h07, 3'b001, 1, 0, 0, 0);
        fire(7);
        expect_msg("R10 offset 1", 4'b0010, 8'h70, 8'h07, 3'b001, 1, 0, 0, 0);
        fire(7);
        expect_msg("R10 offset 2", 4'b0100, 8'h70, 8'h07, 3'b001, 1, 0, 0, 0);
        fire(7);
        expect_msg("R10 wrap", 4'b0001, 8'h70, 8'h07, 3'b001, 1, 0, 0, 0);
        set_ent(7, 8'h70, 3'b001, 1, 0, 0, 0, 8'h10);
        fire(7);
        expect_flag("R11 logical empty", 3);
        set_ent(7, 8'h70, 3'b001, 1, 0, 0, 0, 8'h07);
        fire(7);
        expect_msg("R11 R10 offset kept", 4'b0010, 8'h70, 8'h07, 3'b001, 1, 0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < NPINS; i++) ent[i] = '0;
        ldr = {8'h08, 8'h04, 8'h02, 8'h01};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fields();
        t_bcast();
        t_phys_oob();
        t_ext();
        t_illegal();
        t_mask();
        t_edge();
        t_priority();
        t_handshake();
        t_lowpri();
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        report();
        $finish;
    end
endmodule